// File: doc/BRIEF.md
# Windowed Event Counter Bank

A bank of independent event counters. Each counter picks one per-cycle event strobe through its own select code and counts that event while a measurement window is open. Counting uses the core clock. A sleep indication stops all counting. An initialise pulse clears every counter, every overflow flag and the window state.

The window has three modes. In run-to-break mode, counting follows the program run flag. In the two condition modes, one condition-match pulse opens the window and the other closes it. The direction depends on the mode. In these modes a match only moves the window and never produces a break request.

A counter that would pass its maximum value stops at all ones and raises a sticky overflow flag. Software then knows that the value cannot be trusted.

Top module: `perf_window_unit`

## Requirements
- R1: After synchronous reset, all counts, overflow flags, `brk_req` and `cfg_err` are zero.
- R2: Each counter has its own select field. Counter i uses `ev_sel[i*SEL_W +: SEL_W]`. Code 0 disables the counter. Code k (1..NUM_EV) counts cycles in which `ev_strobe[k-1]` is high. Counters do not affect each other.
- R3: Select code BRANCH_CODE (default 3) adds 2 per counted event. Every other code adds 1.
- R4: `win_mode`=0 (run-to-break), or the spare code 3: an event in cycle t is counted when `run` is high in cycle t.
- R5: `win_mode`=1: `cond_a_hit` opens the window and `cond_b_hit` closes it. Events count from the cycle after the opening pulse up to and including the cycle of the closing pulse.
- R6: `win_mode`=2: the same as R5 with the roles swapped. `cond_b_hit` opens the window and `cond_a_hit` closes it.
- R7: A closing pulse while the window is closed has no effect. Opening and closing pulses together while the window is closed leave it closed, and nothing is counted. An opening pulse while the window is open has no effect.
- R8: While `core_sleep` is high, no counter changes.
- R9: If an increment would pass 2^CNT_W-1, the count becomes all ones and its overflow flag is set. Both stay that way until reset or initialise.
- R10: In mode 0 or 3, `brk_req` is high in the cycle after any condition pulse. In modes 1 and 2, `brk_req` stays low.
- R11: `cfg_err` is high in the cycle after any cycle in which the mode is 1 or 2 and every select code is 0. Otherwise it is low.
- R12: `init` clears all counts, overflow flags and the window state in the next cycle. Any event in that cycle is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Clear counters, flags and window |
| core_sleep | input | 1 | Core sleeping; counting frozen |
| run | input | 1 | Program running flag |
| cond_a_hit | input | 1 | Condition A match pulse |
| cond_b_hit | input | 1 | Condition B match pulse |
| win_mode | input | 2 | Window mode: 0 run, 1 A to B, 2 B to A, 3 as 0 |
| ev_strobe | input | NUM_EV | Per-cycle event strobes |
| ev_sel | input | NUM_CNT*SEL_W | Packed per-counter select codes |
| cnt_val | output | NUM_CNT*CNT_W | Packed counter values |
| cnt_ovf | output | NUM_CNT | Sticky overflow flags |
| brk_req | output | 1 | Break request (run mode only) |
| cfg_err | output | 1 | Condition window with no counter enabled |

## Verification
Every result appears one clock after the cycle of the stimulus that causes it. This holds for a counted event, a window pulse, an initialise, a break request and the configuration error. The only difference is that a window opened in cycle t first gates events in cycle t+1. The bench drives inputs on the falling edge and runs its model on the rising edge from the same inputs. It compares every output on the next falling edge, so each compare looks at the value due after exactly one register. Counters are built 8 bits wide so that saturation and the branch step of two across the limit can be reached in a short run.

// File: rtl/perf_pkg.sv
package perf_pkg;
  typedef enum logic [1:0] {
    WM_RUN  = 2'd0,
    WM_AB   = 2'd1,
    WM_BA   = 2'd2,
    WM_SPARE = 2'd3
  } win_mode_e;

  function automatic logic is_cond_mode(input logic [1:0] m);
    return (m == WM_AB) || (m == WM_BA);
  endfunction
endpackage

// File: rtl/perf_window_ctl.sv
module perf_window_ctl
  import perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int SEL_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     init_i,
  input  logic                     run_i,
  input  logic                     cond_a_i,
  input  logic                     cond_b_i,
  input  logic [1:0]               mode_i,
  input  logic [NUM_CNT*SEL_W-1:0] sel_i,
  output logic                     gate_o,
  output logic                     break_o,
  output logic                     cfg_err_o
);
  logic win_q;
  logic cmode, open_p, close_p;

  assign cmode   = is_cond_mode(mode_i);
  assign open_p  = (mode_i == WM_AB) ? cond_a_i : cond_b_i;
  assign close_p = (mode_i == WM_AB) ? cond_b_i : cond_a_i;
  assign gate_o  = cmode ? win_q : run_i;

  always_ff @(posedge clk) begin
    if (rst || init_i)                win_q <= 1'b0;
    else if (!cmode)                  win_q <= 1'b0;
    else if (!win_q && open_p && !close_p) win_q <= 1'b1;
    else if (win_q && close_p)        win_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      break_o   <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      break_o   <= !cmode && (cond_a_i || cond_b_i);
      cfg_err_o <= cmode && (sel_i == '0);
    end
  end

  // R10: condition pulses never request a break in condition modes
  p_quiet_break_r10: assert property (@(posedge clk) disable iff (rst)
    is_cond_mode(mode_i) |=> !break_o);

  // R11: error only flagged after a condition mode
  p_err_needs_window_r11: assert property (@(posedge clk) disable iff (rst)
    !is_cond_mode(mode_i) |=> !cfg_err_o);

  // R7: closed window in condition mode stays closed on a lone close pulse
  p_close_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (cmode && !win_q && !open_p) |=> !win_q);
endmodule

// File: rtl/perf_event_cnt.sv
module perf_event_cnt #(
  parameter int CNT_W       = 32,
  parameter int SEL_W       = 3,
  parameter int NUM_EV      = 7,
  parameter int BRANCH_CODE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              gate_i,
  input  logic              sleep_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [NUM_EV-1:0] ev_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             hit, bump;
  logic [CNT_W:0]   step, sum;

  always_comb begin
    hit = 1'b0;
    for (int k = 1; k <= NUM_EV; k++)
      if (sel_i == SEL_W'(k)) hit = ev_i[k-1];
  end

  assign step = (sel_i == SEL_W'(BRANCH_CODE)) ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
  assign sum  = {1'b0, cnt_q} + step;
  assign bump = hit && gate_i && !sleep_i && !ovf_q;

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (bump) begin
      if (sum[CNT_W]) begin
        cnt_q <= '1;
        ovf_q <= 1'b1;
      end else begin
        cnt_q <= sum[CNT_W-1:0];
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !init_i) |=> (ovf_q && cnt_q == '1));

  p_sleep_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !init_i) |=> $stable(cnt_q));

  p_off_freeze_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_i == '0 && !init_i) |=> $stable(cnt_q));

  p_step_bound_r3: assert property (@(posedge clk) disable iff (rst)
    !init_i |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(2)));
endmodule

// File: rtl/perf_window_unit.sv
module perf_window_unit #(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 32,
  parameter int NUM_EV      = 7,
  parameter int SEL_W       = 3,
  parameter int BRANCH_CODE = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     init,
  input  logic                     core_sleep,
  input  logic                     run,
  input  logic                     cond_a_hit,
  input  logic                     cond_b_hit,
  input  logic [1:0]               win_mode,
  input  logic [NUM_EV-1:0]        ev_strobe,
  input  logic [NUM_CNT*SEL_W-1:0] ev_sel,
  output logic [NUM_CNT*CNT_W-1:0] cnt_val,
  output logic [NUM_CNT-1:0]       cnt_ovf,
  output logic                     brk_req,
  output logic                     cfg_err
);
  logic gate;

  perf_window_ctl #(.NUM_CNT(NUM_CNT), .SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rst(rst), .init_i(init), .run_i(run),
    .cond_a_i(cond_a_hit), .cond_b_i(cond_b_hit), .mode_i(win_mode),
    .sel_i(ev_sel), .gate_o(gate), .break_o(brk_req), .cfg_err_o(cfg_err)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    perf_event_cnt #(
      .CNT_W(CNT_W), .SEL_W(SEL_W), .NUM_EV(NUM_EV), .BRANCH_CODE(BRANCH_CODE)
    ) u_cnt (
      .clk(clk), .rst(rst), .init_i(init), .gate_i(gate), .sleep_i(core_sleep),
      .sel_i(ev_sel[i*SEL_W +: SEL_W]), .ev_i(ev_strobe),
      .cnt_o(cnt_val[i*CNT_W +: CNT_W]), .ovf_o(cnt_ovf[i])
    );
  end
endmodule

// File: tb/sim_perf_window_unit.sv
module sim_perf_window_unit;
  localparam int NC = 4, CW = 8, NE = 7, SW = 3, BC = 3;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst, init, core_sleep, run, ca, cb;
  logic [1:0] mode;
  logic [NE-1:0] ev;
  logic [NC*SW-1:0] sel;
  logic [NC*CW-1:0] cnt_val;
  logic [NC-1:0] cnt_ovf;
  logic brk_req, cfg_err;

  always #4 clk = ~clk;

  perf_window_unit #(.NUM_CNT(NC), .CNT_W(CW), .NUM_EV(NE), .SEL_W(SW), .BRANCH_CODE(BC)) u0 (
    .clk(clk), .rst(rst), .init(init), .core_sleep(core_sleep), .run(run),
    .cond_a_hit(ca), .cond_b_hit(cb), .win_mode(mode), .ev_strobe(ev), .ev_sel(sel),
    .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .brk_req(brk_req), .cfg_err(cfg_err)
  );

  int m_cnt [NC];
  bit m_ovf [NC];
  bit m_win, m_brk, m_err;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  // behavioural reference, evaluated on the rising edge
  always @(posedge clk) begin
    bit cm, op, cl, g;
    int s;
    cm = (mode == 2'd1) || (mode == 2'd2);
    op = (mode == 2'd1) ? ca : cb;
    cl = (mode == 2'd1) ? cb : ca;
    g  = cm ? m_win : run;
    if (rst) begin
      m_brk = 0; m_err = 0;
    end else begin
      m_brk = !cm && (ca || cb);
      m_err = cm && (sel == '0);
    end
    if (rst || init) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_ovf[i] = 0; end
      m_win = 0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        s = int'(sel[i*SW +: SW]);
        if (s != 0 && s <= NE && ev[s-1] && g && !core_sleep && !m_ovf[i]) begin
          m_cnt[i] += (s == BC) ? 2 : 1;
          if (m_cnt[i] > MAXV) begin m_cnt[i] = MAXV; m_ovf[i] = 1; end
        end
      end
      if (!cm) m_win = 0;
      else if (!m_win && op && !cl) m_win = 1;
      else if (m_win && cl) m_win = 0;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NC; i++) begin
        chk($sformatf("count%0d", i), int'(cnt_val[i*CW +: CW]), m_cnt[i]);
        chk($sformatf("ovf%0d (R9)", i), int'(cnt_ovf[i]), int'(m_ovf[i]));
      end
      chk("brk_req (R10)", int'(brk_req), int'(m_brk));
      chk("cfg_err (R11)", int'(cfg_err), int'(m_err));
    end
  end

  task automatic setsel(input int a, input int b, input int c, input int d);
    sel = {SW'(d), SW'(c), SW'(b), SW'(a)};
  endtask

  task automatic cyc(input int n, input bit rnd);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ca = 0; cb = 0; init = 0;
      ev = rnd ? NE'($urandom) : ev;
    end
  endtask

  task automatic pulse(input bit a, input bit b);
    @(negedge clk);
    ca = a; cb = b; ev = NE'($urandom);
    @(negedge clk);
    ca = 0; cb = 0;
  endtask

  task automatic do_init;
    @(negedge clk); init = 1; ev = '1;
    @(negedge clk); init = 0;
  endtask

  initial begin
    #1200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1; init = 0; core_sleep = 0; run = 0; ca = 0; cb = 0; mode = 0; ev = 0;
    setsel(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: outputs at zero after reset
    tag = "R1"; cyc(2, 0);
    chk("reset count0 (R1)", int'(cnt_val[CW-1:0]), 0);

    // R2/R4: run-to-break mode, mixed selects, one disabled
    tag = "R2_R4"; mode = 0; setsel(1, 2, 0, 5); run = 1;
    cyc(20, 1); run = 0; cyc(10, 1); run = 1; cyc(10, 1);
    mode = 3; cyc(10, 1); run = 0; cyc(5, 1);
    // R3: branch code steps by two
    tag = "R3"; do_init; setsel(3, 3, 4, 7); run = 1; cyc(30, 1); run = 0;

    // R5: A opens, B closes
    tag = "R5"; do_init; mode = 1; setsel(1, 3, 6, 2);
    cyc(5, 1); pulse(1, 0); cyc(12, 1); pulse(0, 1); cyc(8, 1);
    pulse(1, 0); ev = '1; cyc(4, 0); pulse(0, 1); cyc(3, 1);
    // R6: B opens, A closes
    tag = "R6"; do_init; mode = 2; pulse(1, 0); cyc(6, 1); pulse(0, 1); cyc(10, 1);
    pulse(1, 0); cyc(6, 1);
    // R7: stray close, simultaneous pulses, reopen while open
    tag = "R7"; do_init; mode = 1; pulse(0, 1); cyc(5, 1); pulse(1, 1); cyc(6, 1);
    pulse(1, 0); cyc(3, 1); pulse(1, 0); cyc(3, 1); pulse(1, 1); cyc(5, 1);

    // R8: sleep freezes counting
    tag = "R8"; do_init; mode = 0; run = 1; setsel(1, 2, 3, 4);
    cyc(5, 1); core_sleep = 1; ev = '1; cyc(10, 0); core_sleep = 0; cyc(5, 1);

    // R9: saturation and sticky overflow, branch crossing the limit
    tag = "R9"; do_init; setsel(1, 3, 2, 0); ev = 7'b0000101; cyc(300, 0);
    ev = 7'b0000010; cyc(20, 0); run = 0;
    // R12: initialise clears flags and counts
    tag = "R12"; do_init; cyc(3, 0); run = 1; ev = '1; cyc(4, 0); do_init; cyc(3, 1); run = 0;

    // R10: break only in run mode
    tag = "R10"; mode = 0; pulse(1, 0); pulse(0, 1); mode = 2; pulse(1, 0); pulse(0, 1); cyc(2, 0);
    // R11: condition mode with every counter off
    tag = "R11"; mode = 1; setsel(0, 0, 0, 0); cyc(4, 1); setsel(0, 0, 5, 0); cyc(3, 1);
    mode = 0; setsel(0, 0, 0, 0); cyc(3, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule